// File: doc/BRIEF.md
# Crystal Oscillator Warm-Up Controller

This block sits between software and a low-frequency crystal oscillator. A single writable enable bit asks the oscillator to run. A readable cold flag tells software whether the crystal is still settling. After each start, the controller counts raw crystal cycles. Until a full warm-up window of 2^CNT_W cycles (32768 by default) has gone by, it holds back both the gated crystal clock and the ready indication.

Power-on reset and sleep both leave the oscillator stopped and the crystal marked cold. A request to start is refused while an external clock is present or selected. An external clock that appears after the crystal is already running does not stop it. Stopping the oscillator throws away the warm-up progress, so every restart pays the full window again.

Top module: `xosc_warmup_ctrl`

## Requirements
- R1: After reset, read bit 0 (enable) is 0, read bit 1 (cold) is 1, all other read bits are 0, and both the run request and the ready output are 0.
- R2: Writing 1 to the enable bit sets read bit 0 and the run request one clock after the write cycle, with cold still 1.
- R3: Writing 0 to the enable bit clears it one clock after the write and sets cold again in the same cycle. Ready drops, and the gated crystal clock stops pulsing.
- R4: A write of 1 has no effect while the external-clock-detected input is 1.
- R5: A write of 1 has no effect while the external-clock-select input is 1.
- R6: If either external-clock input becomes 1 while the enable bit is already 1, the enable bit stays 1 and ready stays 1.
- R7: While sleep is 1, the enable bit reads 0 and cold reads 1 from the next clock on, and a write of 1 has no effect.
- R8: During the first 2^CNT_W crystal cycles after the enable reaches the crystal domain, the gated crystal clock produces no pulse and cold stays 1.
- R9: Once the warm-up count completes, cold reads 0 and ready is 1 after the synchronizer delay.
- R10: Every pulse on the gated crystal clock rises with a raw crystal rising edge and lasts a full high phase. No partial pulse appears.
- R11: A restart after a stop needs another full 2^CNT_W-cycle warm-up before cold clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset (system domain) |
| xtal_clk | input | 1 | Raw crystal oscillator clock |
| sleep_i | input | 1 | Sleep mode active |
| ext_det_i | input | 1 | External clock detected |
| ext_sel_i | input | 1 | External clock selected by configuration |
| wr_en_i | input | 1 | Write strobe for the enable bit |
| wr_bit_i | input | 1 | Value written to the enable bit |
| rd_data_o | output | REG_W | Status read: bit 0 enable, bit 1 cold, others 0 |
| osc_run_o | output | 1 | Run request to the analog oscillator |
| xtal_gclk_o | output | 1 | Glitch-free gated crystal clock |
| xtal_ready_o | output | 1 | Crystal warmed up and enabled (system domain) |

## Verification
Writes and sleep show up in the read value one system clock after the cycle in which they are driven. The bench therefore queues each expected read and compares it at the falling edge of the next clock. Warm-up completion arrives about SYNC_N crystal cycles plus 2^CNT_W crystal cycles plus SYNC_N+1 system clocks after the enable write. Because the two clocks are asynchronous, the bench does not look for an exact edge. It samples at two points: 68 crystal cycles before the earliest possible end, where cold must still be 1, and 100 crystal cycles after it, where cold must be 0. Pulse width and edge alignment of the gated clock are measured on every pulse it emits.

// File: rtl/xosc_pkg.sv
package xosc_pkg;

    localparam int EN_BIT   = 0;
    localparam int COLD_BIT = 1;

    typedef struct packed {
        logic cold;
        logic en;
    } xosc_stat_t;

    localparam xosc_stat_t STAT_OFF = '{cold: 1'b1, en: 1'b0};

    function automatic logic set_blocked(input logic det, input logic sel);
        return det | sel;
    endfunction

endpackage

// File: rtl/xosc_sync.sv
module xosc_sync #(
    parameter int   N       = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [N-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) stg <= {N{RST_VAL}};
        else     stg <= {stg[N-2:0], d};
    end

    assign q = stg[N-1];
endmodule

// File: rtl/xosc_warmup_cnt.sv
module xosc_warmup_cnt #(
    parameter int CNT_W = 15
) (
    input  logic xclk,
    input  logic clr,
    output logic done_o
);
    localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt;
    logic             done;

    always_ff @(posedge xclk) begin
        if (clr) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!done) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) done <= 1'b1;
        end
    end

    assign done_o = done;
endmodule

// File: rtl/xosc_clk_gate.sv
module xosc_clk_gate (
    input  logic xclk,
    input  logic en,
    output logic gclk
);
    logic en_lat;

    always_latch begin
        if (!xclk) en_lat = en;
    end

    assign gclk = xclk & en_lat;
endmodule

// File: rtl/xosc_warmup_ctrl.sv
module xosc_warmup_ctrl
    import xosc_pkg::*;
#(
    parameter int CNT_W  = 15,
    parameter int SYNC_N = 2,
    parameter int REG_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             xtal_clk,
    input  logic             sleep_i,
    input  logic             ext_det_i,
    input  logic             ext_sel_i,
    input  logic             wr_en_i,
    input  logic             wr_bit_i,
    output logic [REG_W-1:0] rd_data_o,
    output logic             osc_run_o,
    output logic             xtal_gclk_o,
    output logic             xtal_ready_o
);
    xosc_stat_t stat_q, stat_d;
    logic       done_s, done_s_q, done_rise;
    logic       rst_x, en_x, done_x;

    // System clock domain: enable bit and cold flag
    assign done_rise = done_s & ~done_s_q;

    always_comb begin
        stat_d = stat_q;
        if (sleep_i) begin
            stat_d = STAT_OFF;
        end else begin
            if (wr_en_i) begin
                if (!wr_bit_i)
                    stat_d.en = 1'b0;
                else if (!set_blocked(ext_det_i, ext_sel_i))
                    stat_d.en = 1'b1;
            end
            if (!stat_d.en)     stat_d.cold = 1'b1;
            else if (done_rise) stat_d.cold = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q   <= STAT_OFF;
            done_s_q <= 1'b0;
        end else begin
            stat_q   <= stat_d;
            done_s_q <= done_s;
        end
    end

    always_comb begin
        rd_data_o           = '0;
        rd_data_o[EN_BIT]   = stat_q.en;
        rd_data_o[COLD_BIT] = stat_q.cold;
    end

    assign osc_run_o    = stat_q.en;
    assign xtal_ready_o = stat_q.en & ~stat_q.cold;

    // Crystal clock domain
    xosc_sync #(.N(SYNC_N), .RST_VAL(1'b1)) u_rst_x (
        .clk(xtal_clk), .rst(1'b0), .d(rst), .q(rst_x)
    );

    xosc_sync #(.N(SYNC_N), .RST_VAL(1'b0)) u_en_x (
        .clk(xtal_clk), .rst(rst_x), .d(stat_q.en), .q(en_x)
    );

    xosc_warmup_cnt #(.CNT_W(CNT_W)) u_cnt (
        .xclk(xtal_clk), .clr(rst_x | ~en_x), .done_o(done_x)
    );

    xosc_clk_gate u_gate (
        .xclk(xtal_clk), .en(done_x & en_x), .gclk(xtal_gclk_o)
    );

    // Warm-up completion back into the system domain
    xosc_sync #(.N(SYNC_N), .RST_VAL(1'b0)) u_done_s (
        .clk(clk), .rst(rst), .d(done_x), .q(done_s)
    );
endmodule

// File: rtl/xosc_warmup_chk.sv
module xosc_warmup_chk #(
    parameter int REG_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             sleep_i,
    input logic             ext_det_i,
    input logic             ext_sel_i,
    input logic             wr_en_i,
    input logic             wr_bit_i,
    input logic [REG_W-1:0] rd_data_o,
    input logic             xtal_ready_o
);
    logic en, cold;
    assign en   = rd_data_o[0];
    assign cold = rd_data_o[1];

    p_reg_upper_r1: assert property (@(posedge clk) disable iff (rst)
        rd_data_o[REG_W-1:2] == '0);

    p_off_cold_r3: assert property (@(posedge clk) disable iff (rst)
        !en |-> cold);

    p_lock_det_r4: assert property (@(posedge clk) disable iff (rst)
        (!en && ext_det_i) |=> !en);

    p_lock_sel_r5: assert property (@(posedge clk) disable iff (rst)
        (!en && ext_sel_i) |=> !en);

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (en && !sleep_i && !(wr_en_i && !wr_bit_i)) |=> en);

    p_sleep_r7: assert property (@(posedge clk) disable iff (rst)
        sleep_i |=> (!en && cold));

    p_ready_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(xtal_ready_o) |-> $past(cold));

    p_restart_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(en) |-> cold);
endmodule

bind xosc_warmup_ctrl xosc_warmup_chk #(.REG_W(REG_W)) u_chk (
    .clk(clk), .rst(rst), .sleep_i(sleep_i), .ext_det_i(ext_det_i),
    .ext_sel_i(ext_sel_i), .wr_en_i(wr_en_i), .wr_bit_i(wr_bit_i),
    .rd_data_o(rd_data_o), .xtal_ready_o(xtal_ready_o)
);

// File: tb/xosc_warmup_ctrl_tb.sv
`timescale 1ns/1ps
module xosc_warmup_ctrl_tb;
    localparam int CNT_W  = 15;
    localparam int REG_W  = 8;
    localparam int WARM   = 1 << CNT_W;
    localparam int XHALF  = 7;

    logic clk = 1'b0, xtal_clk = 1'b0, rst = 1'b1;
    logic sleep_i = 0, ext_det_i = 0, ext_sel_i = 0, wr_en_i = 0, wr_bit_i = 0;
    logic [REG_W-1:0] rd_data_o;
    logic osc_run_o, xtal_gclk_o, xtal_ready_o;

    always #10 clk = ~clk;
    always #(XHALF) xtal_clk = ~xtal_clk;

    xosc_warmup_ctrl #(.CNT_W(CNT_W), .SYNC_N(2), .REG_W(REG_W)) u_dut (
        .clk(clk), .rst(rst), .xtal_clk(xtal_clk), .sleep_i(sleep_i),
        .ext_det_i(ext_det_i), .ext_sel_i(ext_sel_i), .wr_en_i(wr_en_i),
        .wr_bit_i(wr_bit_i), .rd_data_o(rd_data_o), .osc_run_o(osc_run_o),
        .xtal_gclk_o(xtal_gclk_o), .xtal_ready_o(xtal_ready_o)
    );

    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    typedef struct {
        logic [REG_W-1:0] rd;
        logic             rdy;
        string            tag;
    } exp_t;
    exp_t sb[$];

    // gated clock monitoring for R8/R10
    int  gcount = 0, gbad = 0;
    time t_rise = 0;
    always @(posedge xtal_gclk_o) begin
        gcount++;
        t_rise = $time;
        if (xtal_clk !== 1'b1) gbad++;
    end
    always @(negedge xtal_gclk_o) begin
        if ($time - t_rise != XHALF) gbad++;
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic push_exp(input logic [REG_W-1:0] rd, input logic rdy, input string tag);
        exp_t e;
        e.rd = rd; e.rdy = rdy; e.tag = tag;
        sb.push_back(e);
    endtask

    // scoreboard monitor: compares one queued item per system clock
    always begin
        @(negedge clk);
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_checks++;
            if (rd_data_o !== e.rd || xtal_ready_o !== e.rdy) begin
                n_fail++;
                $display("FAIL %s actual rd=%h rdy=%b expected rd=%h rdy=%b",
                         e.tag, rd_data_o, xtal_ready_o, e.rd, e.rdy);
            end
        end
    end

    task automatic write_en(input logic v, input logic [REG_W-1:0] rd, input logic rdy,
                            input string tag);
        @(negedge clk);
        wr_en_i = 1'b1; wr_bit_i = v;
        @(negedge clk);
        wr_en_i = 1'b0; wr_bit_i = 1'b0;
        push_exp(rd, rdy, tag);
    endtask

    task automatic wait_x(input int n);
        repeat (n) @(posedge xtal_clk);
        @(negedge clk);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #3_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        int g0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        push_exp(8'h02, 1'b0, "R1 reset state");
        #2;
        check(osc_run_o === 1'b0, "R1 run request after reset", osc_run_o, 0);

        ext_det_i = 1'b1;
        write_en(1'b1, 8'h02, 1'b0, "R4 set blocked by detect");
        ext_det_i = 1'b0; ext_sel_i = 1'b1;
        write_en(1'b1, 8'h02, 1'b0, "R5 set blocked by select");
        ext_sel_i = 1'b0;
        sleep_i = 1'b1;
        write_en(1'b1, 8'h02, 1'b0, "R7 set ignored in sleep");
        sleep_i = 1'b0;

        write_en(1'b1, 8'h03, 1'b0, "R2 enable set, cold");
        #2;
        check(osc_run_o === 1'b1, "R2 run request", osc_run_o, 1);

        wait_x(WARM - 68);
        push_exp(8'h03, 1'b0, "R8 still cold in warm-up");
        check(gcount == 0, "R8 no gated pulse in warm-up", gcount, 0);
        wait_x(168);
        push_exp(8'h01, 1'b0 | 1'b1, "R9 warm, ready");
        @(negedge clk);
        check(gcount > 0, "R9 gated clock running", gcount, 1);

        ext_det_i = 1'b1; ext_sel_i = 1'b1;
        repeat (4) @(negedge clk);
        push_exp(8'h01, 1'b1, "R6 enable held under ext clock");
        write_en(1'b1, 8'h01, 1'b1, "R6 rewrite under ext clock");
        ext_det_i = 1'b0; ext_sel_i = 1'b0;

        write_en(1'b0, 8'h02, 1'b0, "R3 disable");
        wait_x(10);
        g0 = gcount;
        wait_x(40);
        check(gcount == g0, "R3 gated clock stopped", gcount, g0);

        g0 = gcount;
        write_en(1'b1, 8'h03, 1'b0, "R11 restart cold");
        wait_x(WARM - 68);
        push_exp(8'h03, 1'b0, "R11 still cold before full warm-up");
        check(gcount == g0, "R11 no pulse before full warm-up", gcount, g0);
        wait_x(168);
        push_exp(8'h01, 1'b1, "R11 warm again");

        @(negedge clk);
        sleep_i = 1'b1;
        @(negedge clk);
        push_exp(8'h02, 1'b0, "R7 sleep forces off");
        @(negedge clk);
        sleep_i = 1'b0;
        @(negedge clk);
        #2;
        check(osc_run_o === 1'b0, "R7 run request dropped", osc_run_o, 0);

        repeat (3) @(negedge clk);
        check(gbad == 0, "R10 full-width gated pulses", gbad, 0);
        summary();
    end
endmodule